// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block recovers bytes from a single idle-high serial line. It looks at the line on each pulse of a sampling tick that runs at sixteen times the bit rate. A frame begins with a low start bit, which is confirmed half a bit later. Eight data bits follow, least significant first. An optional parity bit comes next, and the frame ends with one stop bit. The bits collect in an internal shift register. When the frame is complete, the byte moves to a holding register that a processor reads.

Four status flags describe the most recent reception: receive-full, overrun, parity error and framing error. Each error follows its own rule. An overrun discards the new byte and keeps the held byte and the full flag. A parity or framing error still delivers the byte but does not raise the full flag. The processor clears the full flag with a read strobe and the error flags with a separate clear strobe. Two level-type interrupt requests, one for good data and one for errors, follow the flags. A single enable gates both of them.

Top module: `serial_rx_status`

## Requirements
- R1: After reset, rxData is 0, all four flags are 0 and both interrupt requests are 0.
- R2: A frame is one low start bit, 8 data bits with bit 0 first, an optional parity bit and one high stop bit. An error-free frame that ends while rxFull is 0 copies the byte to rxData and sets rxFull.
- R3: The start bit is re-sampled 8 ticks after it is detected. If the line is high again at that point, the event is discarded: no flag or data changes, and the next real frame is received correctly.
- R4: If a frame ends while rxFull is 1 and dataRead is not asserted in that cycle, overrunErr is set, rxData keeps the old byte, and rxFull stays 1. parityErr and frameErr are not changed by that frame.
- R5: With parityOn=1, the expected parity bit is the XOR of the 8 data bits when parityOdd=0, and its inverse when parityOdd=1. A mismatch sets parityErr and still copies the byte to rxData, but leaves rxFull at 0.
- R6: A stop bit sampled as 0 sets frameErr, still copies the byte to rxData, and leaves rxFull at 0. No new frame starts until the line has returned high.
- R7: A one-cycle dataRead pulse clears rxFull.
- R8: A one-cycle errClear pulse clears overrunErr, parityErr and frameErr.
- R9: irqRxDone equals irqEnable AND rxFull. irqRxErr equals irqEnable AND the OR of the three error flags. Both are levels.
- R10: With parityOn=0, no parity bit is expected, and parityErr is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxLine | input | 1 | Serial line, idle high |
| parityOn | input | 1 | Static: 1 expects a parity bit after the data |
| parityOdd | input | 1 | Static: 1 selects odd parity, 0 selects even parity |
| irqEnable | input | 1 | Gates both interrupt requests |
| dataRead | input | 1 | Read strobe that clears rxFull |
| errClear | input | 1 | Strobe that clears the three error flags |
| rxData | output | 8 | Receive data register |
| rxFull | output | 1 | Receive data register holds an unread byte |
| overrunErr | output | 1 | Sticky overrun flag |
| parityErr | output | 1 | Sticky parity-error flag |
| frameErr | output | 1 | Sticky framing-error flag |
| irqRxDone | output | 1 | Receive-complete interrupt request |
| irqRxErr | output | 1 | Receive-error interrupt request |

## Verification
Bytes with mixed bit patterns (0xA5, 0x3C, 0xC3, 0x01) are sent with parity off. These show whether the bit order is correct and whether the data bits are confused with the stop bit. With parity on, the same byte is sent under even and under odd parity, once with the right parity bit and once with the wrong one. This tells a correct parity computation from an inverted one, and checks that the byte is still delivered when the parity is wrong. The error cases are run separately: a frame that ends while the full flag is still set, a low stop bit, and a short low glitch. Each of these must leave its own mark on the data and on the flags. Finally, the interrupt enable is switched off and back on, which separates the request outputs from the flags behind them.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP,
    RX_HOLD
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic parityCap;
    logic finish;
  } rxStrobe_t;

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineSync,
  input  logic      parityOn,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int IDX_W = $clog2(DATA_BITS);

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic              atCentre;
  logic              atHalf;

  assign atCentre = (tickCnt == CNT_W'(OVERSAMPLE - 1));
  assign atHalf   = (tickCnt == CNT_W'(HALF - 1));

  always_comb begin
    strobe.shiftEn   = sampleTick && (state == RX_DATA)   && atCentre;
    strobe.parityCap = sampleTick && (state == RX_PARITY) && atCentre;
    strobe.finish    = sampleTick && (state == RX_STOP)   && atCentre;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (sampleTick) begin
      case (state)
        RX_IDLE: begin
          tickCnt <= '0;
          if (!lineSync) state <= RX_START;
        end
        RX_START: begin
          if (atHalf) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= lineSync ? RX_IDLE : RX_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (atCentre) begin
            tickCnt <= '0;
            if (bitIdx == IDX_W'(DATA_BITS - 1)) begin
              state <= parityOn ? RX_PARITY : RX_STOP;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_PARITY: begin
          if (atCentre) begin
            tickCnt <= '0;
            state   <= RX_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (atCentre) begin
            tickCnt <= '0;
            state   <= lineSync ? RX_IDLE : RX_HOLD;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_HOLD: begin
          if (lineSync) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobe_t            strobe,
  input  logic                 parityOn,
  input  logic                 parityOdd,
  input  logic                 irqEnable,
  input  logic                 dataRead,
  input  logic                 errClear,
  output logic                 lineSync,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 overrunErr,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 irqRxDone,
  output logic                 irqRxErr
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [DATA_BITS-1:0]   shiftReg;
  logic                   parityBit;
  logic                   parityBad;
  logic                   stopBad;
  logic                   fullHeld;
  logic                   deliver;

  // Metastability guard on the asynchronous line; idle level is high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rxLine};
  end
  assign lineSync = syncChain[SYNC_STAGES-1];

  // Bits arrive least significant first, so shift in from the top.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (strobe.shiftEn)   shiftReg  <= {lineSync, shiftReg[DATA_BITS-1:1]};
      if (strobe.parityCap) parityBit <= lineSync;
    end
  end

  assign parityBad = parityOn && (parityBit != ((^shiftReg) ^ parityOdd));
  assign stopBad   = !lineSync;
  assign fullHeld  = rxFull && !dataRead;
  assign deliver   = strobe.finish && !fullHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxFull     <= 1'b0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      if (deliver) rxData <= shiftReg;

      if (deliver && !parityBad && !stopBad) rxFull <= 1'b1;
      else if (dataRead)                     rxFull <= 1'b0;

      if (strobe.finish && fullHeld) overrunErr <= 1'b1;
      else if (errClear)             overrunErr <= 1'b0;

      if (deliver && parityBad) parityErr <= 1'b1;
      else if (errClear)        parityErr <= 1'b0;

      if (deliver && stopBad) frameErr <= 1'b1;
      else if (errClear)      frameErr <= 1'b0;
    end
  end

  assign irqRxDone = irqEnable && rxFull;
  assign irqRxErr  = irqEnable && (overrunErr || parityErr || frameErr);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleTick,
  input  logic                 rxLine,
  input  logic                 parityOn,
  input  logic                 parityOdd,
  input  logic                 irqEnable,
  input  logic                 dataRead,
  input  logic                 errClear,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxFull,
  output logic                 overrunErr,
  output logic                 parityErr,
  output logic                 frameErr,
  output logic                 irqRxDone,
  output logic                 irqRxErr
);

  rxStrobe_t strobe;
  logic      lineSync;

  serial_rx_ctrl #(
    .DATA_BITS (DATA_BITS),
    .OVERSAMPLE(OVERSAMPLE)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .lineSync  (lineSync),
    .parityOn  (parityOn),
    .strobe    (strobe)
  );

  serial_rx_dpath #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .strobe    (strobe),
    .parityOn  (parityOn),
    .parityOdd (parityOdd),
    .irqEnable (irqEnable),
    .dataRead  (dataRead),
    .errClear  (errClear),
    .lineSync  (lineSync),
    .rxData    (rxData),
    .rxFull    (rxFull),
    .overrunErr(overrunErr),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .irqRxDone (irqRxDone),
    .irqRxErr  (irqRxErr)
  );

endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 parityOn,
  input logic                 irqEnable,
  input logic                 dataRead,
  input logic                 errClear,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 rxFull,
  input logic                 overrunErr,
  input logic                 parityErr,
  input logic                 frameErr,
  input logic                 irqRxDone,
  input logic                 irqRxErr
);

  // R4: an overrun leaves the held byte and the full flag in place
  a_r4_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> ($stable(rxData) && rxFull));

  // R4: the overrunning frame does not touch the other error flags
  a_r4_overrun_alone: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> (!$rose(parityErr) && !$rose(frameErr)));

  // R5 and R6: a frame with a parity or stop error never raises full
  a_r5_error_no_full: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(parityErr) || $rose(frameErr)) |-> !$rose(rxFull));

  // R7: full only falls after a read strobe
  a_r7_full_falls_on_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(dataRead));

  // R8: error flags only fall after a clear strobe
  a_r8_flags_fall_on_clear: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(overrunErr) || $fell(parityErr) || $fell(frameErr)) |-> $past(errClear));

  // R9: no request while the enable is low
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> (!irqRxDone && !irqRxErr));

  // R10: parity errors need parity checking to be on
  a_r10_no_parity_when_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> parityOn);

endmodule

bind serial_rx_status serial_rx_status_chk #(.DATA_BITS(DATA_BITS)) chk_i (.*);

// File: tb/serial_rx_status_tb_top.sv
`timescale 1ns/1ps
module serial_rx_status_tb_top;

  localparam int CLK_PER_TICK = 4;
  localparam int CLK_PER_BIT  = CLK_PER_TICK * 16;

  typedef struct {
    string      tag;
    logic [7:0] data;
    bit         full;
    bit         ovr;
    bit         par;
    bit         frm;
    bit         irqD;
    bit         irqE;
  } sbItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       irqEnable = 1'b1;
  logic       dataRead = 1'b0;
  logic       errClear = 1'b0;
  logic [7:0] rxData;
  logic       rxFull, overrunErr, parityErr, frameErr, irqRxDone, irqRxErr;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  sbItem_t sbQ[$];

  // model state, kept from the requirements
  logic [7:0] mData = 8'h00;
  bit mFull = 0, mOvr = 0, mPar = 0, mFrm = 0;

  always #5 clk = ~clk;

  serial_rx_status dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .parityOn(parityOn), .parityOdd(parityOdd), .irqEnable(irqEnable),
    .dataRead(dataRead), .errClear(errClear), .rxData(rxData),
    .rxFull(rxFull), .overrunErr(overrunErr), .parityErr(parityErr),
    .frameErr(frameErr), .irqRxDone(irqRxDone), .irqRxErr(irqRxErr)
  );

  initial begin : tickGen
    int div;
    div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % CLK_PER_TICK;
      sampleTick = (div == 0);
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic pushExpect(input string tag);
    sbItem_t it;
    it.tag  = tag;
    it.data = mData;
    it.full = mFull;
    it.ovr  = mOvr;
    it.par  = mPar;
    it.frm  = mFrm;
    it.irqD = irqEnable && mFull;
    it.irqE = irqEnable && (mOvr || mPar || mFrm);
    sbQ.push_back(it);
  endtask

  // monitor: compares the design against each expected item
  initial begin : monitor
    sbItem_t it;
    forever begin
      @(negedge clk);
      if (sbQ.size() != 0) begin
        it = sbQ.pop_front();
        check(it.tag, "rxData",     int'(rxData),     int'(it.data));
        check(it.tag, "rxFull",     int'(rxFull),     int'(it.full));
        check(it.tag, "overrunErr", int'(overrunErr), int'(it.ovr));
        check(it.tag, "parityErr",  int'(parityErr),  int'(it.par));
        check(it.tag, "frameErr",   int'(frameErr),   int'(it.frm));
        check(it.tag, "irqRxDone",  int'(irqRxDone),  int'(it.irqD));
        check(it.tag, "irqRxErr",   int'(irqRxErr),   int'(it.irqE));
      end
    end
  end

  task automatic holdBits(input int n);
    repeat (n * CLK_PER_BIT) @(negedge clk);
  endtask

  // drives one frame, updates the model and pushes the expected result
  task automatic sendFrame(input string tag, input logic [7:0] d,
                           input bit wrongParity, input bit stopBit);
    bit expPar;
    bit parFail;
    @(negedge clk);
    rxLine = 1'b0;
    holdBits(1);
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i];
      holdBits(1);
    end
    parFail = 0;
    if (parityOn) begin
      expPar = (^d) ^ parityOdd;
      rxLine = wrongParity ? ~expPar : expPar;
      parFail = wrongParity;
      holdBits(1);
    end
    rxLine = stopBit;
    holdBits(1);
    rxLine = 1'b1;
    holdBits(1);
    if (mFull) begin
      mOvr = 1;
    end else begin
      mData = d;
      if (parFail) mPar = 1;
      if (!stopBit) mFrm = 1;
      if (!parFail && stopBit) mFull = 1;
    end
    pushExpect(tag);
    wait (sbQ.size() == 0);
  endtask

  task automatic doRead(input string tag);
    @(negedge clk); dataRead = 1'b1;
    @(negedge clk); dataRead = 1'b0;
    mFull = 0;
    pushExpect(tag);
    wait (sbQ.size() == 0);
  endtask

  task automatic doClear(input string tag);
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
    mOvr = 0; mPar = 0; mFrm = 0;
    pushExpect(tag);
    wait (sbQ.size() == 0);
  endtask

  initial begin : stimulus
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    pushExpect("R1");                        // reset state
    wait (sbQ.size() == 0);

    // R2: good frames, parity off
    sendFrame("R2", 8'hA5, 0, 1);
    doRead("R7");
    sendFrame("R2", 8'h3C, 0, 1);
    // R4: second frame before any read
    sendFrame("R4", 8'h81, 0, 1);
    doClear("R8");
    doRead("R7");

    // R5: even parity, then odd parity
    parityOn = 1'b1; parityOdd = 1'b0;
    sendFrame("R5", 8'h0F, 0, 1);
    doRead("R7");
    sendFrame("R5", 8'h07, 1, 1);
    doClear("R8");
    parityOdd = 1'b1;
    sendFrame("R5", 8'h07, 0, 1);
    doRead("R7");
    sendFrame("R5", 8'hE0, 1, 1);
    doClear("R8");

    // R6: low stop bit, then a good frame must still follow
    sendFrame("R6", 8'h55, 0, 0);
    doClear("R8");
    sendFrame("R6", 8'h6B, 0, 1);
    doRead("R7");

    // R3: short low glitch is discarded
    parityOn = 1'b0; parityOdd = 1'b0;
    @(negedge clk); rxLine = 1'b0;
    repeat (4 * CLK_PER_TICK) @(negedge clk);
    rxLine = 1'b1;
    holdBits(2);
    pushExpect("R3");
    wait (sbQ.size() == 0);
    sendFrame("R3", 8'hC3, 0, 1);
    doRead("R7");

    // R10: parity off never reports a parity error
    sendFrame("R10", 8'h01, 0, 1);
    doRead("R7");
    sendFrame("R10", 8'hFE, 0, 1);
    doRead("R7");

    // R9: requests follow the enable
    irqEnable = 1'b0;
    sendFrame("R9", 8'h5A, 0, 1);
    sendFrame("R9", 8'hE7, 0, 1);
    @(negedge clk); irqEnable = 1'b1;
    pushExpect("R9");
    wait (sbQ.size() == 0);
    doClear("R9");
    doRead("R9");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule